// File: doc/BRIEF.md
# Board System Configuration Register Bank

This block is a 4 KB window of 32-bit control and identification words, reached over a simple single-cycle bus. Each access is one cycle of `bus_valid`, with `bus_write` selecting the direction, a 12-bit byte address and 32-bit write data. Software uses it to:

- steer a memory remap line;
- light a row of LEDs;
- hold a few board-specific configuration words;
- read fixed identification values.

It also reports the lock state of eight clock DLLs. A software-writable mask selects which DLLs must be locked for the summary bit to be set.

The identification value is a parameter, and it decides which optional words exist. The part-number field is a 12-bit field at bits [15:4] of that value. A wide board has part number 0x524 or 0x547 and gains two extra words. Only part 0x524 gains a third. On other parts those offsets behave as unmapped. Bad accesses get no error response. Reads of them return zero and writes to them are dropped.

Top module: `sysreg_bank`

## Requirements
- R1: After reset:
  - `remap_o` equals bit 0 of `CFG0_INIT`.
  - `led_o` is zero.
  - `cfg1_o`, `cfg2_o`, `cfg5_o` and `cfg6_o` are zero.
  - With all DLL lock inputs high, a read of the DLL word (offset 0x100) returns 0xFFFF0001.
- R2: A write to offset 0x000 stores the whole word in the remap control word. That word is returned by reads of 0x000 and shown on `cfg0_o`. Its bit 0 drives `remap_o` from the next clock edge onward.
- R3: A write to offset 0x004 stores the LED word. Bit i of that word drives `led_o[i]` for i below `NUM_LED`, active high, from the next clock edge. The LED outputs change on no other access.
- R4: Offsets 0x008 and 0x014 are read/write words only when the part number (ID bits [15:4]) is 0x524 or 0x547. Offset 0x018 is a read/write word only for 0x524. Otherwise these offsets read zero, ignore writes, and their `cfgN_o` outputs stay zero.
- R5: The following offsets are read-only, and writes to them have no effect:

  | Offset | Read value |
  |---|---|
  | 0x00C | always zero |
  | 0x010 | parameter `INFO_VALUE` |
  | 0xFF8 | parameter `AID_VALUE` |
  | 0xFFC | parameter `ID_VALUE` |
- R6: The DLL word at offset 0x100 reads as follows. Only bits [31:24] are writable; the reset value of the mask is 0xFF.

  | Bits | Content |
  |---|---|
  | [31:24] | lock mask |
  | [23:16] | the live `dll_locked_i` vector |
  | [15:1] | zero |
  | [0] | AND over i of (`dll_locked_i[i]` OR NOT mask[i]) |
- R7: Any other offset reads zero and ignores writes. This includes any address not on a 4-byte boundary.
- R8: Read data is registered. A read presented in cycle N returns its data on `bus_rdata` in cycle N+1. After any cycle with no read, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dll_locked_i | input | 8 | Per-DLL lock indication |
| remap_o | output | 1 | Remap control line |
| led_o | output | NUM_LED | LED drive, active high |
| cfg0_o | output | 32 | Remap control word |
| cfg1_o | output | 32 | LED control word |
| cfg2_o | output | 32 | Optional configuration word at 0x008 |
| cfg5_o | output | 32 | Optional configuration word at 0x014 |
| cfg6_o | output | 32 | Optional configuration word at 0x018 |

## Verification
The properties assume that `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` are stable across each clock edge. They also assume that `dll_locked_i` is sampled together with the read that reports it. The stimulus drives every input on the falling edge and holds it through the following rising edge. The DLL check then compares the reported bits with the lock vector held during the read. The sweep writes junk to every non-writable offset, then reads back every aligned offset on three part-number variants. It also walks all 256 lock patterns under several masks, so the summary-bit arithmetic is checked at the boundary where a single unmasked DLL drops.

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter int          NUM_LED    = 10,
  parameter logic [31:0] CFG0_INIT  = 32'h0000_0001,
  parameter logic [31:0] INFO_VALUE = 32'h0000_0003,
  parameter logic [31:0] AID_VALUE  = 32'h0200_0008,
  parameter logic [31:0] ID_VALUE   = 32'h4104_5240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [7:0]         dll_locked_i,
  output logic               remap_o,
  output logic [NUM_LED-1:0] led_o,
  output logic [31:0]        cfg0_o,
  output logic [31:0]        cfg1_o,
  output logic [31:0]        cfg2_o,
  output logic [31:0]        cfg5_o,
  output logic [31:0]        cfg6_o
);
  localparam logic [11:0] PART      = ID_VALUE[15:4];
  localparam bit          HAS_WIDE  = (PART == 12'h524) || (PART == 12'h547);
  localparam bit          HAS_BRAM  = (PART == 12'h524);

  localparam logic [11:0] A_REMAP = 12'h000;
  localparam logic [11:0] A_LED   = 12'h004;
  localparam logic [11:0] A_OPT2  = 12'h008;
  localparam logic [11:0] A_SW    = 12'h00C;
  localparam logic [11:0] A_INFO  = 12'h010;
  localparam logic [11:0] A_OPT5  = 12'h014;
  localparam logic [11:0] A_OPT6  = 12'h018;
  localparam logic [11:0] A_DLL   = 12'h100;
  localparam logic [11:0] A_AID   = 12'hFF8;
  localparam logic [11:0] A_ID    = 12'hFFC;

  wire wr = bus_valid &&  bus_write;
  wire rd = bus_valid && !bus_write;

  logic [31:0] remap_q, led_q, opt2_q, opt5_q, opt6_q;
  logic [7:0]  dll_mask;
  logic [31:0] rmux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remap_q  <= CFG0_INIT;
      led_q    <= '0;
      dll_mask <= 8'hFF;
    end else if (wr) begin
      if (bus_addr == A_REMAP) remap_q  <= bus_wdata;
      if (bus_addr == A_LED)   led_q    <= bus_wdata;
      if (bus_addr == A_DLL)   dll_mask <= bus_wdata[31:24];
    end
  end

  if (HAS_WIDE) begin : g_wide
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        opt2_q <= '0;
        opt5_q <= '0;
      end else if (wr) begin
        if (bus_addr == A_OPT2) opt2_q <= bus_wdata;
        if (bus_addr == A_OPT5) opt5_q <= bus_wdata;
      end
    end
  end else begin : g_narrow
    assign opt2_q = '0;
    assign opt5_q = '0;
  end

  if (HAS_BRAM) begin : g_bram
    always_ff @(posedge clk) begin
      if (!rst_n)                        opt6_q <= '0;
      else if (wr && bus_addr == A_OPT6) opt6_q <= bus_wdata;
    end
  end else begin : g_nobram
    assign opt6_q = '0;
  end

  wire all_locked = &(dll_locked_i | ~dll_mask);

  always_comb begin
    case (bus_addr)
      A_REMAP: rmux = remap_q;
      A_LED:   rmux = led_q;
      A_OPT2:  rmux = opt2_q;
      A_SW:    rmux = '0;
      A_INFO:  rmux = INFO_VALUE;
      A_OPT5:  rmux = opt5_q;
      A_OPT6:  rmux = opt6_q;
      A_DLL:   rmux = {dll_mask, dll_locked_i, 15'b0, all_locked};
      A_AID:   rmux = AID_VALUE;
      A_ID:    rmux = ID_VALUE;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd ? rmux : '0;
  end

  assign remap_o = remap_q[0];
  assign led_o   = led_q[NUM_LED-1:0];
  assign cfg0_o  = remap_q;
  assign cfg1_o  = led_q;
  assign cfg2_o  = opt2_q;
  assign cfg5_o  = opt5_q;
  assign cfg6_o  = opt6_q;
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk #(
  parameter int          NUM_LED    = 10,
  parameter logic [31:0] INFO_VALUE = 32'h0,
  parameter logic [31:0] AID_VALUE  = 32'h0,
  parameter logic [31:0] ID_VALUE   = 32'h0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [11:0]        bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [7:0]         dll_locked_i,
  input logic [7:0]         dll_mask,
  input logic               remap_o,
  input logic [NUM_LED-1:0] led_o,
  input logic [31:0]        cfg6_o
);
  localparam logic [11:0] PART   = ID_VALUE[15:4];
  localparam bit          NO6    = (PART != 12'h524);

  wire rd = bus_valid && !bus_write;
  wire wr = bus_valid &&  bus_write;

  // R2
  remap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 12'h000) |=> remap_o == $past(bus_wdata[0]));

  // R3
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == 12'h004) |=> $stable(led_o));

  // R4
  opt6_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (NO6 && rd && bus_addr == 12'h018) |=> bus_rdata == 32'h0);

  // R4
  opt6_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    NO6 |-> cfg6_o == 32'h0);

  // R5
  aid_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == 12'hFF8) |=> bus_rdata == AID_VALUE);

  // R5
  sw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == 12'h00C) |=> bus_rdata == 32'h0);

  // R6
  dll_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == 12'h100) |=>
      (bus_rdata[0] == &($past(dll_locked_i) | ~$past(dll_mask))) &&
      (bus_rdata[23:16] == $past(dll_locked_i)) && (bus_rdata[15:1] == 15'h0));

  // R6
  dll_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == 12'h100) |=> $stable(dll_mask));

  // R7
  unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == 32'h0);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> bus_rdata == 32'h0);
endmodule

bind sysreg_bank sysreg_bank_chk #(
  .NUM_LED(NUM_LED), .INFO_VALUE(INFO_VALUE),
  .AID_VALUE(AID_VALUE), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .dll_locked_i(dll_locked_i), .dll_mask(dll_mask), .remap_o(remap_o),
  .led_o(led_o), .cfg6_o(cfg6_o)
);

// File: tb/sysreg_bank_test.sv
module sysreg_bank_test;
  localparam int          NL    = 10;
  localparam logic [31:0] INIT0 = 32'h0000_0001;
  localparam logic [31:0] INFO  = 32'h0000_0003;
  localparam logic [31:0] AID   = 32'h0200_0008;
  localparam logic [31:0] ID_A  = 32'h4104_5240;
  localparam logic [31:0] ID_B  = 32'h4104_5470;
  localparam logic [31:0] ID_C  = 32'h4104_5110;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  locked = 8'hFF;
  always #5 clk = ~clk;

  logic [31:0] rd_a, rd_b, rd_c;
  logic        rm_a, rm_b, rm_c;
  logic [NL-1:0] led_a, led_b, led_c;
  logic [31:0] c0a, c1a, c2a, c5a, c6a, c0b, c1b, c2b, c5b, c6b, c0c, c1c, c2c, c5c, c6c;

  sysreg_bank #(.NUM_LED(NL), .CFG0_INIT(INIT0), .INFO_VALUE(INFO), .AID_VALUE(AID), .ID_VALUE(ID_A)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .dll_locked_i(locked), .remap_o(rm_a), .led_o(led_a),
    .cfg0_o(c0a), .cfg1_o(c1a), .cfg2_o(c2a), .cfg5_o(c5a), .cfg6_o(c6a));
  sysreg_bank #(.NUM_LED(NL), .CFG0_INIT(INIT0), .INFO_VALUE(INFO), .AID_VALUE(AID), .ID_VALUE(ID_B)) uut_b (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .dll_locked_i(locked), .remap_o(rm_b), .led_o(led_b),
    .cfg0_o(c0b), .cfg1_o(c1b), .cfg2_o(c2b), .cfg5_o(c5b), .cfg6_o(c6b));
  sysreg_bank #(.NUM_LED(NL), .CFG0_INIT(INIT0), .INFO_VALUE(INFO), .AID_VALUE(AID), .ID_VALUE(ID_C)) uut_c (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_c), .dll_locked_i(locked), .remap_o(rm_c), .led_o(led_c),
    .cfg0_o(c0c), .cfg1_o(c1c), .cfg2_o(c2c), .cfg5_o(c5c), .cfg6_o(c6c));

  int n_chk = 0, n_bad = 0;
  logic [31:0] m0, m1, m2, m5, m6;
  logic [7:0]  mk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int inst, input logic [11:0] a);
    logic p2 = (inst < 2);
    logic p6 = (inst == 0);
    logic [31:0] idv = (inst == 0) ? ID_A : (inst == 1) ? ID_B : ID_C;
    case (a)
      12'h000: return m0;
      12'h004: return m1;
      12'h008: return p2 ? m2 : 32'h0;
      12'h00C: return 32'h0;
      12'h010: return INFO;
      12'h014: return p2 ? m5 : 32'h0;
      12'h018: return p6 ? m6 : 32'h0;
      12'h100: return {mk, locked, 15'h0, &(locked | ~mk)};
      12'hFF8: return AID;
      12'hFFC: return idv;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    case (a)
      12'h000: m0 = d;
      12'h004: m1 = d;
      12'h008: m2 = d;
      12'h014: m5 = d;
      12'h018: m6 = d;
      12'h100: mk = d[31:24];
      default: ;
    endcase
  endtask

  task automatic rd_all(input string req, input logic [11:0] a);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    check(req, rd_a, model(0, a));
    check(req, rd_b, model(1, a));
    check(req, rd_c, model(2, a));
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m0 = INIT0; m1 = 0; m2 = 0; m5 = 0; m6 = 0; mk = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 remap", {31'h0, rm_a}, {31'h0, INIT0[0]});
    check("R1 led", {22'h0, led_a}, 32'h0);
    check("R1 cfg1", c1a, 32'h0);
    check("R1 cfg2", c2a, 32'h0);
    check("R1 cfg5", c5a, 32'h0);
    check("R1 cfg6", c6a, 32'h0);
    rd_all("R1 dll", 12'h100);
    check("R1 dll literal", rd_a, 32'hFFFF_0001);

    // R2 remap writes both polarities
    wr(12'h000, 32'h1234_5670);
    check("R2 remap low", {31'h0, rm_a}, 32'h0);
    check("R2 cfg0_o", c0a, 32'h1234_5670);
    wr(12'h000, 32'h8765_4321);
    check("R2 remap high", {31'h0, rm_c}, 32'h1);
    // R3 LEDs
    wr(12'h004, 32'hFFFF_F3A5);
    check("R3 led", {22'h0, led_a}, 32'h0000_03A5);
    wr(12'h004, 32'h0000_0C5A);
    check("R3 led", {22'h0, led_b}, 32'h0000_005A);
    // R4 optional words
    wr(12'h008, 32'hA5A5_0008);
    wr(12'h014, 32'h5A5A_0014);
    wr(12'h018, 32'hC3C3_0018);
    check("R4 cfg2 wide", c2a, 32'hA5A5_0008);
    check("R4 cfg6 547", c6b, 32'h0);
    check("R4 cfg5 547", c5b, 32'h5A5A_0014);
    check("R4 cfg2 narrow", c2c, 32'h0);
    check("R4 cfg6 narrow", c6c, 32'h0);
    // R6 mask write, low bits ignored
    wr(12'h100, 32'h5A00_FFFE);

    // R5 R7 junk to every non-writable aligned offset plus unaligned ones
    for (int i = 0; i < 1024; i++) begin
      logic [11:0] a = 12'(i * 4);
      if (a != 12'h000 && a != 12'h004 && a != 12'h008 && a != 12'h014 &&
          a != 12'h018 && a != 12'h100)
        wr(a, 32'hDEAD_0000 | 32'(i));
    end
    for (int i = 0; i < 8; i++) begin
      logic [11:0] a = 12'(i * 4 + 1 + (i % 3));
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = 32'hBAD0_BAD0;
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
    end
    check("R3 led after junk", {22'h0, led_a}, 32'h0000_005A);
    check("R2 cfg0 after junk", c0a, 32'h8765_4321);

    // R4 R5 R7 full read sweep of the window
    locked = 8'hC3;
    for (int i = 0; i < 1024; i++) rd_all("R7 sweep", 12'(i * 4));
    for (int i = 0; i < 12; i++)   rd_all("R7 unaligned", 12'(i * 4 + 1 + (i % 3)));
    rd_all("R5 id", 12'hFFC);
    rd_all("R4 opt6", 12'h018);

    // R6 lock-summary sweep
    for (int k = 0; k < 6; k++) begin
      logic [7:0] mv;
      case (k)
        0: mv = 8'hFF; 1: mv = 8'h00; 2: mv = 8'h0F;
        3: mv = 8'h80; 4: mv = 8'h01; default: mv = 8'h5A;
      endcase
      wr(12'h100, {mv, 24'h00FFFF});
      for (int l = 0; l < 256; l++) begin
        locked = 8'(l);
        rd_all("R6 dll", 12'h100);
      end
    end

    // R8 idle and write cycles give zero read data
    locked = 8'hFF;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 12'hFF8;
    @(negedge clk);
    bus_valid = 0;
    check("R8 latency", rd_a, AID);
    @(negedge clk);
    check("R8 idle zero", rd_a, 32'h0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 12'hFFC; bus_wdata = 32'h1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check("R8 write zero", rd_b, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule